// File: doc/BRIEF.md
# Delay-Line Calibration Sweep Engine

This block tunes the transmit and receive delay codes of a double-data-rate flash read path without software involvement. After a start pulse it turns on the PHY, pipeline and DDR protocol enables. It then steps through candidate delay pairs. For each pair it drives both delay codes, gives the delay lines a resynchronisation edge and waits for them to settle. It then requests a test read and compares the returned bytes with a golden pattern that is held locally.

The search has two stages. The first stage walks the transmit code upward. For each transmit code it finds the lowest receive code that reads correctly, and it notes the run of transmit codes that have any passing receive code. The midpoint of that run becomes the transmit setting. The second stage holds that transmit code and walks the receive code upward from the receive code recorded for it, until the first failing read. The midpoint of that passing receive run becomes the receive setting. The final pair is left on the delay outputs and is also reported. A done flag ends every calibration. The error flag is raised if no transmit code passes, and the calibrated flag is raised only on success.

Top module: `dll_cal_sweep`

## Requirements
- R1: After synchronous reset, `rd_req`, `phy_en`, `pipe_en`, `ddr_en`, `done`, `err` and `calibrated` are all 0.
- R2: Stage one visits transmit codes in rising order from 0. At each transmit code it visits receive codes in rising order from 0 and moves to the next transmit code at the first receive code that passes.
- R3: The transmit window opens at the first transmit code that has a passing receive code. It closes at the code just below the first later transmit code with no passing receive code, and stage one stops there. If the maximum code still passes, the window closes at the maximum code.
- R4: The chosen transmit code is floor((window start + window end) / 2).
- R5: Stage two starts at the receive code recorded for the chosen transmit code and steps upward until a read fails or the maximum code has been read. The chosen receive code is floor((first passing receive code + last passing receive code) / 2).
- R6: For every delay update, `dll_resync` is 0 for at least one cycle and then goes to 1. `rd_req` does not rise until at least RESYNC_WAIT cycles after that rising edge, and the final update also waits this long before `done`.
- R7: A test read passes only when every byte i of `rd_data` (bits 8i+7..8i) equals golden byte i. Golden byte i is written with `gold_we`=1, `gold_addr`=i and `gold_data`.
- R8: If no transmit code passes, the engine sets `done` and `err` and leaves `calibrated` at 0.
- R9: `phy_en`, `pipe_en` and `ddr_en` are 1 from the cycle after `start` until the engine finishes, and are 0 once `done` is 1, whether the calibration succeeded or failed.
- R10: `rd_req` stays at 1 until a cycle with `rd_done`=1, and `tx_dly`/`rx_dly` do not change while a read is outstanding.
- R11: On success, `cal_tx`/`cal_rx` and `tx_dly`/`rx_dly` hold the chosen pair, and `calibrated` is 1 and `err` is 0. The flags `done`, `err` and `calibrated` hold their values until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a calibration |
| gold_we | input | 1 | Golden byte write enable |
| gold_addr | input | $clog2(NBYTES) | Golden byte index |
| gold_data | input | 8 | Golden byte value |
| rd_req | output | 1 | Test read request, held until `rd_done` |
| rd_done | input | 1 | Test read complete, `rd_data` valid |
| rd_data | input | NBYTES*8 | Returned test bytes, byte i at bits 8i+7..8i |
| tx_dly | output | DLY_W | Transmit delay code to the delay line |
| rx_dly | output | DLY_W | Receive delay code to the delay line |
| dll_resync | output | 1 | Delay-line resynchronisation, acts on its rising edge |
| phy_en | output | 1 | PHY enable during calibration |
| pipe_en | output | 1 | PHY pipeline enable during calibration |
| ddr_en | output | 1 | DDR protocol enable during calibration |
| cal_tx | output | DLY_W | Chosen transmit code |
| cal_rx | output | DLY_W | Chosen receive code |
| done | output | 1 | Calibration finished |
| err | output | 1 | No passing transmit code found |
| calibrated | output | 1 | Calibration succeeded |

## Verification
The enables are due one edge after `start`, so the driver samples them on the next falling edge. A read request is due RESYNC_WAIT edges after the resync edge. The bench counts falling edges from the sampled resync rise to the sampled request rise and requires at least RESYNC_WAIT. `done`, `err`, `calibrated`, the chosen pair and the dropped enables all change on one edge. The monitor therefore waits for `done` to rise and compares all of them on the following falling edge against the expected entry the driver queued, which it computed by hand from the pass window. Any failing pair returns the golden bytes with one byte corrupted, and the corrupted position moves from pair to pair, so every byte position takes part in the comparison.

// File: rtl/dll_cal_pkg.sv
package dll_cal_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_PROG, S_RSYNC, S_WAIT, S_READ, S_EVAL, S_MID, S_LOOK, S_SET, S_FIN
  } cal_state_e;
endpackage

// File: rtl/dll_cal_gold.sv
module dll_cal_gold #(
  parameter int NBYTES = 16,
  localparam int AW = $clog2(NBYTES)
) (
  input  logic                  clk,
  input  logic                  we,
  input  logic [AW-1:0]         waddr,
  input  logic [7:0]            wdata,
  input  logic [NBYTES*8-1:0]   cmp_data,
  output logic                  match
);
  logic [7:0]        gold_q [NBYTES];
  logic [NBYTES-1:0] byte_eq;

  always_ff @(posedge clk) begin
    if (we) gold_q[waddr] <= wdata;
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_cmp
    assign byte_eq[i] = (cmp_data[8*i +: 8] == gold_q[i]);
  end

  assign match = &byte_eq;
endmodule

// File: rtl/dll_cal_rxmem.sv
module dll_cal_rxmem #(
  parameter int DEPTH_W = 7,
  parameter int DATA_W  = 8,
  localparam int DEPTH  = 1 << DEPTH_W
) (
  input  logic               clk,
  input  logic               we,
  input  logic [DEPTH_W-1:0] waddr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [DEPTH_W-1:0] raddr,
  output logic [DATA_W-1:0]  rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/dll_cal_timer.sv
module dll_cal_timer #(
  parameter int WAIT_CYC = 20,
  localparam int CW = $clog2(WAIT_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic kick,
  output logic expired
);
  logic [CW-1:0] cnt_q;
  logic          run_q;

  assign expired = run_q && (cnt_q == CW'(WAIT_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (kick) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (run_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (expired) run_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dll_cal_sweep.sv
module dll_cal_sweep
  import dll_cal_pkg::*;
#(
  parameter int DLY_W       = 7,
  parameter int NBYTES      = 16,
  parameter int RESYNC_WAIT = 20,
  localparam int AW = $clog2(NBYTES),
  localparam int CW = DLY_W + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                gold_we,
  input  logic [AW-1:0]       gold_addr,
  input  logic [7:0]          gold_data,
  output logic                rd_req,
  input  logic                rd_done,
  input  logic [NBYTES*8-1:0] rd_data,
  output logic [DLY_W-1:0]    tx_dly,
  output logic [DLY_W-1:0]    rx_dly,
  output logic                dll_resync,
  output logic                phy_en,
  output logic                pipe_en,
  output logic                ddr_en,
  output logic [DLY_W-1:0]    cal_tx,
  output logic [DLY_W-1:0]    cal_rx,
  output logic                done,
  output logic                err,
  output logic                calibrated
);
  localparam logic [DLY_W-1:0] MAXC = {DLY_W{1'b1}};
  localparam logic [CW-1:0]    NOTF = {CW{1'b1}};

  cal_state_e       state_q;
  logic             stage2_q, final_q, pass_q, ok_q;
  logic [CW-1:0]    tx_start_q;
  logic [DLY_W-1:0] tx_end_q, rx_lo_q, rx_last_q;
  logic             match, expired;
  logic             mem_we;
  logic [CW-1:0]    mem_wdata, mem_rdata;
  logic [CW-1:0]    tx_sum, rx_sum;
  logic [DLY_W-1:0] tx_mid, rx_mid;

  // midpoints: sums fit in DLY_W+1 bits
  assign tx_sum = CW'(tx_start_q[DLY_W-1:0]) + CW'(tx_end_q);
  assign tx_mid = tx_sum[CW-1:1];
  assign rx_sum = CW'(rx_lo_q) + CW'(rx_last_q);
  assign rx_mid = rx_sum[CW-1:1];

  // stage-one record of the first passing receive code per transmit code
  always_comb begin
    mem_we    = 1'b0;
    mem_wdata = NOTF;
    if (state_q == S_EVAL && !stage2_q) begin
      if (pass_q) begin
        mem_we    = 1'b1;
        mem_wdata = {1'b0, rx_dly};
      end else if (rx_dly == MAXC) begin
        mem_we    = 1'b1;
        mem_wdata = NOTF;
      end
    end
  end

  dll_cal_gold #(.NBYTES(NBYTES)) u_gold (
    .clk(clk), .we(gold_we), .waddr(gold_addr), .wdata(gold_data),
    .cmp_data(rd_data), .match(match)
  );

  dll_cal_rxmem #(.DEPTH_W(DLY_W), .DATA_W(CW)) u_rxmem (
    .clk(clk), .we(mem_we), .waddr(tx_dly), .wdata(mem_wdata),
    .raddr(tx_mid), .rdata(mem_rdata)
  );

  dll_cal_timer #(.WAIT_CYC(RESYNC_WAIT)) u_timer (
    .clk(clk), .rst(rst), .kick(state_q == S_RSYNC), .expired(expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_IDLE;
      stage2_q   <= 1'b0;
      final_q    <= 1'b0;
      pass_q     <= 1'b0;
      ok_q       <= 1'b0;
      tx_start_q <= NOTF;
      tx_end_q   <= '0;
      rx_lo_q    <= '0;
      rx_last_q  <= '0;
      tx_dly     <= '0;
      rx_dly     <= '0;
      dll_resync <= 1'b0;
      rd_req     <= 1'b0;
      phy_en     <= 1'b0;
      pipe_en    <= 1'b0;
      ddr_en     <= 1'b0;
      cal_tx     <= '0;
      cal_rx     <= '0;
      done       <= 1'b0;
      err        <= 1'b0;
      calibrated <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (start) begin
          done       <= 1'b0;
          err        <= 1'b0;
          calibrated <= 1'b0;
          phy_en     <= 1'b1;
          pipe_en    <= 1'b1;
          ddr_en     <= 1'b1;
          tx_dly     <= '0;
          rx_dly     <= '0;
          tx_start_q <= NOTF;
          stage2_q   <= 1'b0;
          final_q    <= 1'b0;
          state_q    <= S_PROG;
        end
        S_PROG: begin
          dll_resync <= 1'b0;
          state_q    <= S_RSYNC;
        end
        S_RSYNC: begin
          dll_resync <= 1'b1;
          state_q    <= S_WAIT;
        end
        S_WAIT: if (expired) begin
          if (final_q) begin
            ok_q    <= 1'b1;
            state_q <= S_FIN;
          end else begin
            rd_req  <= 1'b1;
            state_q <= S_READ;
          end
        end
        S_READ: if (rd_done) begin
          rd_req  <= 1'b0;
          pass_q  <= match;
          state_q <= S_EVAL;
        end
        S_EVAL: begin
          if (!stage2_q) begin
            if (pass_q) begin
              if (tx_start_q == NOTF) tx_start_q <= {1'b0, tx_dly};
              if (tx_dly == MAXC) begin
                tx_end_q <= MAXC;
                state_q  <= S_MID;
              end else begin
                tx_dly  <= tx_dly + 1'b1;
                rx_dly  <= '0;
                state_q <= S_PROG;
              end
            end else if (rx_dly != MAXC) begin
              rx_dly  <= rx_dly + 1'b1;
              state_q <= S_PROG;
            end else if (tx_start_q != NOTF) begin
              tx_end_q <= tx_dly - 1'b1;
              state_q  <= S_MID;
            end else if (tx_dly == MAXC) begin
              ok_q    <= 1'b0;
              state_q <= S_FIN;
            end else begin
              tx_dly  <= tx_dly + 1'b1;
              rx_dly  <= '0;
              state_q <= S_PROG;
            end
          end else begin
            if (pass_q) begin
              rx_last_q <= rx_dly;
              if (rx_dly == MAXC) state_q <= S_SET;
              else begin
                rx_dly  <= rx_dly + 1'b1;
                state_q <= S_PROG;
              end
            end else begin
              state_q <= S_SET;
            end
          end
        end
        S_MID: begin
          tx_dly  <= tx_mid;
          state_q <= S_LOOK;
        end
        S_LOOK: begin
          rx_dly    <= mem_rdata[DLY_W-1:0];
          rx_lo_q   <= mem_rdata[DLY_W-1:0];
          rx_last_q <= mem_rdata[DLY_W-1:0];
          stage2_q  <= 1'b1;
          state_q   <= S_PROG;
        end
        S_SET: begin
          rx_dly  <= rx_mid;
          final_q <= 1'b1;
          state_q <= S_PROG;
        end
        S_FIN: begin
          phy_en     <= 1'b0;
          pipe_en    <= 1'b0;
          ddr_en     <= 1'b0;
          done       <= 1'b1;
          err        <= !ok_q;
          calibrated <= ok_q;
          if (ok_q) begin
            cal_tx <= tx_dly;
            cal_rx <= rx_dly;
          end
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dll_cal_sweep_chk.sv
module dll_cal_sweep_chk #(
  parameter int DLY_W    = 7,
  parameter int WAIT_CYC = 20
) (
  input logic             clk,
  input logic             rst,
  input logic             rd_req,
  input logic             rd_done,
  input logic [DLY_W-1:0] tx_dly,
  input logic [DLY_W-1:0] rx_dly,
  input logic             dll_resync,
  input logic             phy_en,
  input logic             pipe_en,
  input logic             ddr_en,
  input logic             done,
  input logic             err,
  input logic             calibrated
);
  logic        rs_d;
  logic [15:0] since_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rs_d    <= 1'b0;
      since_q <= '0;
    end else begin
      rs_d <= dll_resync;
      if (dll_resync && !rs_d) since_q <= 16'd1;
      else if (since_q != 16'hFFFF) since_q <= since_q + 16'd1;
    end
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req && !rd_done |=> rd_req);

  // R10
  dly_stable_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req && !rd_done |=> $stable(tx_dly) && $stable(rx_dly));

  // R6
  resync_wait_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_req) |-> dll_resync && (since_q >= 16'(WAIT_CYC)));

  // R9
  idle_en_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !phy_en && !pipe_en && !ddr_en && !rd_req);

  // R8
  cal_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(calibrated && err));

  // R11
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    done && !phy_en |=> !phy_en |-> $stable(err) && $stable(calibrated));
endmodule

bind dll_cal_sweep dll_cal_sweep_chk #(.DLY_W(DLY_W), .WAIT_CYC(RESYNC_WAIT)) u_chk (
  .clk(clk), .rst(rst), .rd_req(rd_req), .rd_done(rd_done),
  .tx_dly(tx_dly), .rx_dly(rx_dly), .dll_resync(dll_resync),
  .phy_en(phy_en), .pipe_en(pipe_en), .ddr_en(ddr_en),
  .done(done), .err(err), .calibrated(calibrated)
);

// File: tb/dll_cal_sweep_bench.sv
module dll_cal_sweep_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW  = 5;
  localparam int NB  = 16;
  localparam int WT  = 20;
  localparam int AW  = $clog2(NB);

  typedef struct {
    logic [DW-1:0] tx;
    logic [DW-1:0] rx;
    logic          er;
  } exp_t;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic gold_we = 1'b0;
  logic [AW-1:0] gold_addr = '0;
  logic [7:0] gold_data = '0;
  logic rd_req, rd_done = 1'b0;
  logic [NB*8-1:0] rd_data = '0;
  logic [DW-1:0] tx_dly, rx_dly, cal_tx, cal_rx;
  logic dll_resync, phy_en, pipe_en, ddr_en, done, err, calibrated;

  int tests = 0, fails = 0;
  int win_tl, win_th, win_rl, win_rh;
  exp_t expq[$];
  logic [7:0] gold [NB];
  bit early_seen, moved_seen;
  int resync_edges, since;
  logic prev_rs = 1'b0, prev_req = 1'b0;
  logic [DW-1:0] req_tx, req_rx;
  int runs_checked = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dll_cal_sweep #(.DLY_W(DW), .NBYTES(NB), .RESYNC_WAIT(WT)) u_dll_cal_sweep (
    .clk(clk), .rst(rst), .start(start), .gold_we(gold_we), .gold_addr(gold_addr),
    .gold_data(gold_data), .rd_req(rd_req), .rd_done(rd_done), .rd_data(rd_data),
    .tx_dly(tx_dly), .rx_dly(rx_dly), .dll_resync(dll_resync), .phy_en(phy_en),
    .pipe_en(pipe_en), .ddr_en(ddr_en), .cal_tx(cal_tx), .cal_rx(cal_rx),
    .done(done), .err(err), .calibrated(calibrated)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // flash model: pass window over the delay pair; failing reads corrupt one byte
  initial begin
    forever begin
      @(negedge clk);
      if (rd_req) begin
        repeat (2) @(negedge clk);
        for (int i = 0; i < NB; i++) rd_data[8*i +: 8] = gold[i];
        if (!(int'(tx_dly) >= win_tl && int'(tx_dly) <= win_th &&
              int'(rx_dly) >= win_rl && int'(rx_dly) <= win_rh)) begin
          int b = (int'(tx_dly) + int'(rx_dly)) % NB;
          rd_data[8*b +: 8] = gold[b] ^ 8'h01;
        end
        rd_done = 1'b1;
        @(negedge clk);
        rd_done = 1'b0;
      end
    end
  end

  // resync-to-request spacing and delay stability (R6, R10)
  always @(negedge clk) begin
    if (dll_resync && !prev_rs) begin
      since = 1;
      resync_edges++;
    end else since++;
    if (rd_req && !prev_req) begin
      if (since < WT) early_seen = 1'b1;
      req_tx = tx_dly;
      req_rx = rx_dly;
    end else if (rd_req && prev_req && (tx_dly != req_tx || rx_dly != req_rx))
      moved_seen = 1'b1;
    prev_rs  = dll_resync;
    prev_req = rd_req;
  end

  // monitor: pops expected result when done rises
  initial begin
    forever begin
      exp_t e;
      @(posedge done);
      @(negedge clk);
      e = expq.pop_front();
      check(err == e.er, "R8 err", err, e.er);
      check(calibrated == !e.er, "R11 calibrated", calibrated, !e.er);
      check(!phy_en && !pipe_en && !ddr_en, "R9 enables off", phy_en, 0);
      if (!e.er) begin
        check(cal_tx == e.tx, "R4 chosen tx", cal_tx, e.tx);
        check(cal_rx == e.rx, "R5 chosen rx", cal_rx, e.rx);
        check(tx_dly == e.tx && rx_dly == e.rx, "R11 delays left at pair",
              {tx_dly, rx_dly}, {e.tx, e.rx});
      end
      check(!early_seen, "R6 read before settle wait", early_seen, 0);
      check(resync_edges > 0, "R6 resync edges", resync_edges, 1);
      check(!moved_seen, "R10 delays moved during read", moved_seen, 0);
      runs_checked++;
    end
  end

  // driver: queue the expected outcome, then launch the calibration
  task automatic run(input int tl, th, rl, rh, input int etx, erx, input bit eer);
    exp_t e;
    win_tl = tl; win_th = th; win_rl = rl; win_rh = rh;
    e.tx = DW'(etx); e.rx = DW'(erx); e.er = eer;
    expq.push_back(e);
    early_seen = 0; moved_seen = 0; resync_edges = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(phy_en && pipe_en && ddr_en && !done, "R9 enables on", phy_en, 1);
    @(posedge done);
    repeat (3) @(negedge clk);
    check(done && err == eer, "R11 flags held", done, 1);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NB; i++) gold[i] = 8'(8'h3C + 8'h17 * i);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(!rd_req && !phy_en && !pipe_en && !ddr_en && !done && !err && !calibrated,
          "R1 reset state", {rd_req, phy_en, done, err, calibrated}, 0);
    // R7: load the golden pattern
    for (int i = 0; i < NB; i++) begin
      gold_we = 1'b1; gold_addr = AW'(i); gold_data = gold[i];
      @(negedge clk);
    end
    gold_we = 1'b0;
    // R2 R3 R4 R5 R7: interior window
    run(4, 12, 5, 20, 8, 12, 1'b0);
    // R3 R5: passes up to the maximum code on both axes
    run(0, 31, 0, 31, 15, 15, 1'b0);
    // R3 R5: high window, receive run ends at the maximum code
    run(20, 25, 30, 31, 22, 30, 1'b0);
    // R4 R5: single passing point
    run(7, 7, 9, 9, 7, 9, 1'b0);
    // R8: no passing pair at all
    run(1, 0, 0, 31, 0, 0, 1'b1);
    // R2 R3: recovery after a failed run
    run(2, 5, 3, 4, 3, 3, 1'b0);
    check(runs_checked == 6 && expq.size() == 0, "R11 all results seen", runs_checked, 6);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule